// File: doc/BRIEF.md
# Supply Supervisor Reset Sequencer

This block turns two raw reset causes into one clean system reset for a microprocessor. The first cause is a digital flag from an external supply comparator, which is high while the supply sits below its trip point. The second is an active-low pushbutton line. Both are brought into the clock domain through a two-stage synchronizer. All timing then advances on a clock-enable tick that the surrounding supervisor provides, so the windows are counted in ticks rather than in clocks.

The supply flag is accepted only after it has been seen high on a set number of consecutive ticks, which rejects short dips. The pushbutton is debounced in both directions. Reset goes active in the same cycle that either qualified cause appears and stays active while any cause is present. Once the last cause clears, reset is held for a fixed number of ticks. If a cause returns during that hold, the count starts again from zero. Coming out of the asynchronous reset, the output is active and runs one full hold before its first release.

The pin polarity is a build parameter. A separate status bit always reads high while reset is asserted, whatever the pin polarity.

Top module: `supv_reset_seq`

## Requirements
- R1: During asynchronous reset and directly after it, rst_active_o is 1. With no cause present, it stays 1 after TIMEOUT_TICKS-1 ticks and is 0 after TIMEOUT_TICKS ticks.
- R2: A supply_low_i level held high (1 = below threshold), once synchronized, is accepted on the GLITCH_TICKS-th consecutive tick that sees it high. rst_active_o rises in that same cycle. After GLITCH_TICKS-1 such ticks it is still 0.
- R3: A supply_low_i high period that spans fewer than GLITCH_TICKS ticks has no effect on rst_active_o. A return to 0 clears the partial count, so a second short high period also has no effect.
- R4: Once the supply flag returns to 0, rst_active_o stays 1 through TIMEOUT_TICKS-1 further ticks and is 0 after TIMEOUT_TICKS ticks.
- R5: mr_n_i low (0 = pressed) is accepted after DEBOUNCE_TICKS consecutive ticks that see it low, and rst_active_o is then 1. A low period spanning fewer ticks has no effect.
- R6: While the debounced press lasts, rst_active_o stays 1 for any duration. The hold count starts only after the release has been debounced, so the output is 0 exactly DEBOUNCE_TICKS+TIMEOUT_TICKS ticks after mr_n_i returns high.
- R7: A qualified cause that reappears while the hold is counting restarts the hold from zero. A full TIMEOUT_TICKS is then needed after it clears.
- R8: With ACTIVE_HIGH=0, rst_o is the inverse of rst_active_o (low = reset). With ACTIVE_HIGH=1, rst_o equals rst_active_o. rst_active_o has the same value under both builds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| tick_i | input | 1 | Clock enable for all tick-based windows |
| supply_low_i | input | 1 | Raw comparator flag, 1 while the supply is below threshold |
| mr_n_i | input | 1 | Raw pushbutton line, 0 while pressed |
| rst_o | output | 1 | System reset pin, polarity set by ACTIVE_HIGH |
| rst_active_o | output | 1 | 1 while reset is asserted, independent of polarity |

## Verification
The bench builds two copies of the block with GLITCH_TICKS=4, DEBOUNCE_TICKS=3 and TIMEOUT_TICKS=20. One copy has ACTIVE_HIGH=0 and the other ACTIVE_HIGH=1, and both receive the same inputs. With windows this short, every edge of every window can be checked on the exact tick: the last tick before acceptance or release, and the tick on which it happens. There is also room for a restart that lands in the middle of a hold, well before the hold would have ended. Because both polarities run together, the pin and the status bit can be compared across the two builds on every check.

// File: rtl/supv_pkg.sv
package supv_pkg;
    // Width needed to hold values 0..n inclusive
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction
endpackage

// File: rtl/supv_sync.sv
module supv_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/supv_glitch_filter.sv
module supv_glitch_filter
    import supv_pkg::*;
#(
    parameter int HOLD_TICKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic level_i,
    output logic qual_o
);
    localparam int W = cnt_width(HOLD_TICKS);

    typedef struct packed {
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!level_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != W'(HOLD_TICKS))) begin
            st_d.cnt = st_q.cnt + W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign qual_o = (st_q.cnt == W'(HOLD_TICKS));
endmodule

// File: rtl/supv_debounce.sv
module supv_debounce
    import supv_pkg::*;
#(
    parameter int STABLE_TICKS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic raw_i,
    output logic level_o
);
    localparam int W = cnt_width(STABLE_TICKS);

    typedef struct packed {
        logic         level;
        logic [W-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raw_i == st_q.level) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (st_q.cnt == W'(STABLE_TICKS - 1)) begin
                st_d.level = raw_i;
                st_d.cnt   = '0;
            end else begin
                st_d.cnt = st_q.cnt + W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_o = st_q.level;
endmodule

// File: rtl/supv_stretch.sv
module supv_stretch
    import supv_pkg::*;
#(
    parameter int TIMEOUT_TICKS = 20,
    localparam int CW = cnt_width(TIMEOUT_TICKS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          cause_i,
    output logic          hold_o,
    output logic [CW-1:0] cnt_o
);
    typedef struct packed {
        logic          hold;
        logic [CW-1:0] cnt;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cause_i) begin
            st_d.hold = 1'b1;
            st_d.cnt  = '0;
        end else if (st_q.hold && tick_i) begin
            if (st_q.cnt == CW'(TIMEOUT_TICKS - 1)) begin
                st_d.hold = 1'b0;
                st_d.cnt  = '0;
            end else begin
                st_d.cnt = st_q.cnt + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.hold <= 1'b1;
            st_q.cnt  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hold_o = st_q.hold;
    assign cnt_o  = st_q.cnt;
endmodule

// File: rtl/supv_reset_seq.sv
module supv_reset_seq
    import supv_pkg::*;
#(
    parameter int GLITCH_TICKS   = 4,
    parameter int DEBOUNCE_TICKS = 5000,
    parameter int TIMEOUT_TICKS  = 200000,
    parameter bit ACTIVE_HIGH    = 1'b0,
    parameter int SYNC_STAGES    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic supply_low_i,
    input  logic mr_n_i,
    output logic rst_o,
    output logic rst_active_o
);
    localparam int TCW = cnt_width(TIMEOUT_TICKS);

    logic [1:0]     sync_q;
    logic           sup_sync;
    logic           press_sync;
    logic           sup_qual;
    logic           mr_db;
    logic           cause;
    logic           hold;
    logic [TCW-1:0] stretch_cnt;
    logic           active;

    // bit 1: supply low, bit 0: button pressed (both reset to "absent")
    supv_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({supply_low_i, ~mr_n_i}),
        .q_o   (sync_q)
    );

    assign sup_sync   = sync_q[1];
    assign press_sync = sync_q[0];

    supv_glitch_filter #(.HOLD_TICKS(GLITCH_TICKS)) u_glitch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .level_i (sup_sync),
        .qual_o  (sup_qual)
    );

    supv_debounce #(.STABLE_TICKS(DEBOUNCE_TICKS)) u_debounce (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .raw_i   (press_sync),
        .level_o (mr_db)
    );

    assign cause = sup_qual | mr_db;

    supv_stretch #(.TIMEOUT_TICKS(TIMEOUT_TICKS)) u_stretch (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (tick_i),
        .cause_i (cause),
        .hold_o  (hold),
        .cnt_o   (stretch_cnt)
    );

    // entry is immediate: a present cause asserts reset without waiting on hold
    assign active       = cause | hold;
    assign rst_active_o = active;

    generate
        if (ACTIVE_HIGH) begin : g_pol_high
            assign rst_o = active;
        end else begin : g_pol_low
            assign rst_o = ~active;
        end
    endgenerate
endmodule

// File: rtl/supv_reset_chk.sv
module supv_reset_chk #(
    parameter int TCW = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           tick_i,
    input logic           sup_sync,
    input logic           sup_qual,
    input logic           mr_db,
    input logic [TCW-1:0] stretch_cnt,
    input logic           rst_active_o
);
    p_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_qual) |-> rst_active_o);

    p_qual_needs_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sup_qual) |-> ($past(tick_i) && $past(sup_sync)));

    p_hold_with_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_qual || mr_db) |-> rst_active_o);

    p_release_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_active_o) |-> ($past(tick_i) && !sup_qual && !mr_db));

    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sup_qual || mr_db) |=> (stretch_cnt == '0));
endmodule

bind supv_reset_seq supv_reset_chk #(.TCW(TCW)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .tick_i       (tick_i),
    .sup_sync     (sup_sync),
    .sup_qual     (sup_qual),
    .mr_db        (mr_db),
    .stretch_cnt  (stretch_cnt),
    .rst_active_o (rst_active_o)
);

// File: tb/supv_reset_seq_bench.sv
`timescale 1ns/1ps
module supv_reset_seq_bench;
    localparam int GT = 4;
    localparam int DT = 3;
    localparam int TT = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic supply_low = 1'b0;
    logic mr_n = 1'b1;
    logic rst_lo, act_lo, rst_hi, act_hi;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    supv_reset_seq #(.GLITCH_TICKS(GT), .DEBOUNCE_TICKS(DT), .TIMEOUT_TICKS(TT),
                     .ACTIVE_HIGH(1'b0)) u_supv_reset_seq (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_low_i(supply_low),
        .mr_n_i(mr_n), .rst_o(rst_lo), .rst_active_o(act_lo));

    supv_reset_seq #(.GLITCH_TICKS(GT), .DEBOUNCE_TICKS(DT), .TIMEOUT_TICKS(TT),
                     .ACTIVE_HIGH(1'b1)) u_supv_reset_seq_hi (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .supply_low_i(supply_low),
        .mr_n_i(mr_n), .rst_o(rst_hi), .rst_active_o(act_hi));

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            idle(2);
        end
    endtask

    // checks status and both pins against one expected reset state
    task automatic expect_active(input bit exp, input string tag);
        checks++;
        if (act_lo !== exp || act_hi !== exp || rst_lo !== ~exp || rst_hi !== exp) begin
            failures++;
            $display("FAIL %s: act_lo=%b act_hi=%b rst_lo=%b rst_hi=%b expected active=%b",
                     tag, act_lo, act_hi, rst_lo, rst_hi, exp);
        end
    endtask

    task automatic t_power_on;
        idle(3);
        expect_active(1'b1, "R1 in reset");
        expect_active(1'b1, "R8 polarity in reset");
        @(negedge clk) rst_n = 1'b1;
        idle(3);
        expect_active(1'b1, "R1 just after reset");
        ticks(TT - 1);
        expect_active(1'b1, "R1 one tick before first release");
        ticks(1);
        expect_active(1'b0, "R1 first release");
        expect_active(1'b0, "R8 polarity released");
    endtask

    task automatic t_supply_dip;
        supply_low = 1'b1; idle(3);
        ticks(GT - 1);
        expect_active(1'b0, "R2 before glitch window full");
        ticks(1);
        expect_active(1'b1, "R2 accepted on last window tick");
        expect_active(1'b1, "R8 polarity active");
        supply_low = 1'b0; idle(3);
        expect_active(1'b1, "R4 held at supply clear");
        ticks(TT - 1);
        expect_active(1'b1, "R4 one tick before release");
        ticks(1);
        expect_active(1'b0, "R4 release after timeout");
    endtask

    task automatic t_supply_glitch;
        supply_low = 1'b1; idle(3);
        ticks(GT - 1);
        supply_low = 1'b0; idle(3);
        expect_active(1'b0, "R3 short dip ignored");
        supply_low = 1'b1; idle(3);
        ticks(GT - 1);
        expect_active(1'b0, "R3 count cleared between dips");
        supply_low = 1'b0; idle(3);
        ticks(2);
        expect_active(1'b0, "R3 no reset after dips");
    endtask

    task automatic t_button;
        mr_n = 1'b0; idle(3);
        ticks(DT - 1);
        expect_active(1'b0, "R5 before debounce done");
        ticks(1);
        expect_active(1'b1, "R5 press accepted");
        ticks(TT + 5);
        expect_active(1'b1, "R6 held for long press");
        mr_n = 1'b1; idle(3);
        ticks(DT + TT - 1);
        expect_active(1'b1, "R6 one tick before release");
        ticks(1);
        expect_active(1'b0, "R6 release after debounce plus timeout");
    endtask

    task automatic t_bounce;
        mr_n = 1'b0; idle(3);
        ticks(DT - 1);
        mr_n = 1'b1; idle(3);
        ticks(2);
        expect_active(1'b0, "R5 bounce ignored");
    endtask

    task automatic t_restart;
        supply_low = 1'b1; idle(3);
        ticks(GT);
        supply_low = 1'b0; idle(3);
        ticks(10);
        expect_active(1'b1, "R7 mid timeout");
        supply_low = 1'b1; idle(3);
        ticks(GT);
        supply_low = 1'b0; idle(3);
        ticks(TT - 1);
        expect_active(1'b1, "R7 restarted hold still active");
        ticks(1);
        expect_active(1'b0, "R7 release after full restarted hold");
    endtask

    initial begin
        t_power_on();
        t_supply_dip();
        t_supply_glitch();
        t_button();
        t_bounce();
        t_restart();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            failures++;
            $display("FAIL watchdog: run did not complete, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule